// File: doc/BRIEF.md
# MUX control timeline monitor

This block sits beside the control lines of a Type-C orientation multiplexer and watches them without driving anything. It samples six control levels (cable attached, orientation, multiplexer select, multiplexer enable, alternate-mode entered and hot-plug detect) through two-flop synchronisers. Every change of any of them is written into a small event log. Each log entry holds a snapshot of all six levels and the value of a free-running timestamp counter.

Alongside the log, the block enforces three routing-control invariants. The first is that a select change must not land close to a mode-entry edge. The second is that each attach sees exactly one hot-plug rising edge. The third is that orientation stays put while attached. It also flags a timestamp sequence that fails to increase. Bring-up software reads the log and the counters through a simple address/data read port, and clears them with a one-cycle clear strobe.

Top module: `tc_mux_timeline_mon`

## Requirements
- R1: After reset every read address returns zero. This covers the status word, every counter word, log slots that have not been written, and unmapped addresses.
- R2: A change on any watched input appends one log entry. Entry bits [5:0] hold the post-change levels: bit0 attach, bit1 orientation, bit2 select, bit3 enable, bit4 mode, bit5 hot-plug. Bits [TS_W+5:6] hold the timestamp.
- R3: The timestamp advances by one every clock cycle. The difference between two entries' timestamps equals the number of cycles between the two input changes.
- R4: The log keeps the first DEPTH entries after a clear and drops later events. A dropped event sets the overflow flag (status bit 8). The fill count (status bits [7:0]) stops at DEPTH.
- R5: An event whose timestamp is not strictly greater than the previous event's timestamp sets a sticky monotonic-error flag (status bit 9). The flag stays set until clear.
- R6: The select-in-window total (address DEPTH+1) counts two cases. One is a select change that arrives 0 to WIN cycles after a mode rising edge. The other is a mode rising edge that arrives 1 to WIN cycles after a select change. A coincident pair counts once, and a distance of WIN+1 counts nothing.
- R7: The block counts hot-plug rising edges during an attach. When detach occurs and that count is not one, the hot-plug violation total (address DEPTH+2) increments.
- R8: The block counts orientation changes during an attach. When detach occurs and that count is nonzero, the orientation violation total (address DEPTH+3) increments.
- R9: The per-attach word (address DEPTH+4) holds the hot-plug count in bits [7:0] and the orientation change count in bits [15:8]. Both clear on attach and keep their values through and after detach.
- R10: A clear strobe empties the log and zeroes the overflow flag, the monotonic flag and all three totals. It leaves the per-attach word unchanged.
- R11: Read data appears one clock edge after the address is applied. Addresses 0 to DEPTH-1 are log slots in arrival order. DEPTH to DEPTH+4 are the status word, the three totals and the per-attach word. All other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Clears log, flags and violation totals |
| attach_i | input | 1 | Cable attached level (asynchronous) |
| orient_i | input | 1 | Orientation decision level (asynchronous) |
| sel_i | input | 1 | Multiplexer select level (asynchronous) |
| en_i | input | 1 | Multiplexer enable level (asynchronous) |
| mode_i | input | 1 | Alternate-mode entered level (asynchronous) |
| hpd_i | input | 1 | Hot-plug detect level (asynchronous) |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Read data, one edge after address |

## Verification
An input change passes two synchroniser flops and the edge-detect register. It therefore reaches the log and the counters on the third rising edge after the edge that samples it. Reading that state through the port adds one more edge. The bench changes inputs at falling edges and waits at least five cycles before reading. Each read samples at the falling edge that follows the edge which registers the address. All inputs share the same synchroniser delay, so the window and timestamp checks compare distances counted in cycles. The bench computes those distances from the cycles at which it drove each change, not from absolute timestamp values.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int NSIG = 6;

  // snapshot of watched levels; packed so attach lands in bit 0
  typedef struct packed {
    logic hpd;
    logic mode;
    logic en;
    logic sel;
    logic orient;
    logic attach;
  } tcm_snap_t;
endpackage

// File: rtl/tcm_sync.sv
module tcm_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/tcm_log.sv
module tcm_log #(
  parameter int DEPTH = 8,
  parameter int TS_W  = 24,
  parameter int SW    = 6,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int FILL_W = $clog2(DEPTH + 1),
  localparam int EW     = TS_W + SW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              ev_i,
  input  logic [SW-1:0]     snap_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [EW-1:0]     ent_o,
  output logic [FILL_W-1:0] fill_o,
  output logic              ovf_o,
  output logic              mono_o
);
  logic [EW-1:0]     mem [DEPTH];
  logic [TS_W-1:0]   ts_q, last_ts_q;
  logic              have_last_q;
  logic [FILL_W-1:0] fill_q;
  logic              full, wr_ok;

  assign full  = (fill_q == FILL_W'(DEPTH));
  assign wr_ok = ev_i && !clr_i && !full;

  // free-running stamp
  always_ff @(posedge clk) begin
    if (rst) ts_q <= '0;
    else     ts_q <= ts_q + 1'b1;
  end

  // storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[fill_q[IDX_W-1:0]] <= {ts_q, snap_i};
    ent_o <= mem[rd_idx_i];
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      fill_q      <= '0;
      ovf_o       <= 1'b0;
      mono_o      <= 1'b0;
      have_last_q <= 1'b0;
      last_ts_q   <= '0;
    end else if (ev_i) begin
      if (full) ovf_o <= 1'b1;
      else      fill_q <= fill_q + 1'b1;
      if (have_last_q && (ts_q <= last_ts_q)) mono_o <= 1'b1;
      last_ts_q   <= ts_q;
      have_last_q <= 1'b1;
    end
  end

  assign fill_o = fill_q;

  p_fill_bound_r4: assert property (@(posedge clk) disable iff (rst)
    fill_q <= FILL_W'(DEPTH));
  p_ovf_full_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> full);
  p_ts_step_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (ts_q == $past(ts_q) + 1'b1));
  p_mono_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (mono_o && !clr_i) |=> mono_o);
endmodule

// File: rtl/tcm_rules.sv
module tcm_rules #(
  parameter int WIN   = 16,
  parameter int CNT_W = 8,
  localparam int WCW  = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             att_c,
  input  logic             att_p,
  input  logic             ori_c,
  input  logic             ori_p,
  input  logic             sel_c,
  input  logic             sel_p,
  input  logic             mode_c,
  input  logic             mode_p,
  input  logic             hpd_c,
  input  logic             hpd_p,
  output logic [CNT_W-1:0] sel_tot_o,
  output logic [CNT_W-1:0] hpd_tot_o,
  output logic [CNT_W-1:0] ori_tot_o,
  output logic [CNT_W-1:0] hpd_cnt_o,
  output logic [CNT_W-1:0] ori_cnt_o
);
  localparam logic [WCW-1:0] WLIM = WCW'(WIN);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic sel_chg, mode_rise, att_rise, att_fall, hpd_rise, ori_chg;
  logic win_hit, pre_hit;
  logic [WCW-1:0] since_mode_q, since_sel_q;

  assign sel_chg   = sel_c ^ sel_p;
  assign ori_chg   = ori_c ^ ori_p;
  assign mode_rise = mode_c & ~mode_p;
  assign hpd_rise  = hpd_c & ~hpd_p;
  assign att_rise  = att_c & ~att_p;
  assign att_fall  = ~att_c & att_p;

  // distance trackers, saturating at the window size
  always_ff @(posedge clk) begin
    if (rst) begin
      since_mode_q <= WLIM;
      since_sel_q  <= WLIM;
    end else begin
      if (mode_rise)             since_mode_q <= '0;
      else if (since_mode_q < WLIM) since_mode_q <= since_mode_q + 1'b1;
      if (sel_chg)               since_sel_q <= '0;
      else if (since_sel_q < WLIM)  since_sel_q <= since_sel_q + 1'b1;
    end
  end

  assign win_hit = sel_chg && (mode_rise || (since_mode_q < WLIM));
  assign pre_hit = mode_rise && !sel_chg && (since_sel_q < WLIM);

  // cumulative totals
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      sel_tot_o <= '0;
      hpd_tot_o <= '0;
      ori_tot_o <= '0;
    end else begin
      if ((win_hit || pre_hit) && sel_tot_o != CMAX) sel_tot_o <= sel_tot_o + 1'b1;
      if (att_fall) begin
        if (hpd_cnt_o != CNT_W'(1) && hpd_tot_o != CMAX) hpd_tot_o <= hpd_tot_o + 1'b1;
        if (ori_cnt_o != '0 && ori_tot_o != CMAX)        ori_tot_o <= ori_tot_o + 1'b1;
      end
    end
  end

  // per-attach counters
  always_ff @(posedge clk) begin
    if (rst) begin
      hpd_cnt_o <= '0;
      ori_cnt_o <= '0;
    end else if (att_rise) begin
      hpd_cnt_o <= CNT_W'(hpd_rise);
      ori_cnt_o <= '0;
    end else if (att_c) begin
      if (hpd_rise && hpd_cnt_o != CMAX) hpd_cnt_o <= hpd_cnt_o + 1'b1;
      if (ori_chg && ori_cnt_o != CMAX)  ori_cnt_o <= ori_cnt_o + 1'b1;
    end
  end

  p_tot_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (sel_tot_o >= $past(sel_tot_o)));
  p_hpd_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !att_c |=> $stable(hpd_cnt_o));
  p_ori_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !att_c |=> $stable(ori_cnt_o));
  p_ori_tot_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !att_fall) |=> $stable(ori_tot_o));
endmodule

// File: rtl/tc_mux_timeline_mon.sv
module tc_mux_timeline_mon
  import tcm_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TS_W   = 24,
  parameter int WIN    = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH + 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              attach_i,
  input  logic              orient_i,
  input  logic              sel_i,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic              hpd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int FILL_W = $clog2(DEPTH + 1);
  localparam int EW     = TS_W + NSIG;

  tcm_snap_t raw, cur, prv;
  logic      ev;

  assign raw = '{hpd: hpd_i, mode: mode_i, en: en_i, sel: sel_i,
                 orient: orient_i, attach: attach_i};

  tcm_sync #(.W(NSIG)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(cur)
  );

  always_ff @(posedge clk) begin
    if (rst) prv <= '0;
    else     prv <= cur;
  end

  assign ev = (cur != prv);

  logic [EW-1:0]     ent;
  logic [FILL_W-1:0] fill;
  logic              ovf, mono;

  tcm_log #(.DEPTH(DEPTH), .TS_W(TS_W), .SW(NSIG)) u_log (
    .clk(clk), .rst(rst), .clr_i(clr_i), .ev_i(ev), .snap_i(cur),
    .rd_idx_i(rd_addr_i[IDX_W-1:0]), .ent_o(ent), .fill_o(fill),
    .ovf_o(ovf), .mono_o(mono)
  );

  logic [CNT_W-1:0] sel_tot, hpd_tot, ori_tot, hpd_cnt, ori_cnt;

  tcm_rules #(.WIN(WIN), .CNT_W(CNT_W)) u_rules (
    .clk(clk), .rst(rst), .clr_i(clr_i),
    .att_c(cur.attach), .att_p(prv.attach),
    .ori_c(cur.orient), .ori_p(prv.orient),
    .sel_c(cur.sel),    .sel_p(prv.sel),
    .mode_c(cur.mode),  .mode_p(prv.mode),
    .hpd_c(cur.hpd),    .hpd_p(prv.hpd),
    .sel_tot_o(sel_tot), .hpd_tot_o(hpd_tot), .ori_tot_o(ori_tot),
    .hpd_cnt_o(hpd_cnt), .ori_cnt_o(ori_cnt)
  );

  // register-side read path
  logic [ADDR_W-1:0] off;
  logic [DATA_W-1:0] reg_w, reg_q;
  logic              is_ent, ent_ok, is_ent_q, ent_ok_q;

  assign off    = rd_addr_i - ADDR_W'(DEPTH);
  assign is_ent = (rd_addr_i < ADDR_W'(DEPTH));
  assign ent_ok = (FILL_W'(rd_addr_i[IDX_W-1:0]) < fill);

  always_comb begin
    reg_w = '0;
    case (off)
      ADDR_W'(0): begin
        reg_w[FILL_W-1:0] = fill;
        reg_w[8]          = ovf;
        reg_w[9]          = mono;
      end
      ADDR_W'(1): reg_w[CNT_W-1:0] = sel_tot;
      ADDR_W'(2): reg_w[CNT_W-1:0] = hpd_tot;
      ADDR_W'(3): reg_w[CNT_W-1:0] = ori_tot;
      ADDR_W'(4): begin
        reg_w[CNT_W-1:0]  = hpd_cnt;
        reg_w[8 +: CNT_W] = ori_cnt;
      end
      default: reg_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q    <= '0;
      is_ent_q <= 1'b0;
      ent_ok_q <= 1'b0;
    end else begin
      reg_q    <= is_ent ? '0 : reg_w;
      is_ent_q <= is_ent;
      ent_ok_q <= is_ent && ent_ok;
    end
  end

  always_comb begin
    rd_data_o = reg_q;
    if (is_ent_q) begin
      rd_data_o = '0;
      if (ent_ok_q) rd_data_o[EW-1:0] = ent;
    end
  end

  p_unwritten_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (is_ent_q && !ent_ok_q) |-> (rd_data_o == '0));
  p_hpd_cnt_attach_r9: assert property (@(posedge clk) disable iff (rst)
    (cur.attach && !prv.attach && !cur.hpd) |=> (hpd_cnt == '0));
endmodule

// File: tb/tc_mux_timeline_mon_tb.sv
module tc_mux_timeline_mon_tb;
  localparam int DEPTH = 8, TS_W = 24, WIN = 16, AW = 4;
  localparam int A_ST = DEPTH, A_SEL = DEPTH + 1, A_HPD = DEPTH + 2,
                 A_ORI = DEPTH + 3, A_PA = DEPTH + 4;

  logic clk = 1'b0, rst = 1'b1, clr = 1'b0;
  logic att = 0, ori = 0, sel = 0, en = 0, mode = 0, hpd = 0;
  logic [AW-1:0] ra = '0;
  logic [31:0]   rd;
  logic          att2 = 0;
  logic [3:0]    ra2 = '0;
  logic [31:0]   rd2;

  always #4 clk = ~clk;

  tc_mux_timeline_mon #(.DEPTH(DEPTH), .TS_W(TS_W), .WIN(WIN)) u_dut (
    .clk(clk), .rst(rst), .clr_i(clr), .attach_i(att), .orient_i(ori),
    .sel_i(sel), .en_i(en), .mode_i(mode), .hpd_i(hpd),
    .rd_addr_i(ra), .rd_data_o(rd));

  tc_mux_timeline_mon #(.DEPTH(4), .TS_W(8), .WIN(WIN)) u_dut_wrap (
    .clk(clk), .rst(rst), .clr_i(clr), .attach_i(att2), .orient_i(1'b0),
    .sel_i(1'b0), .en_i(1'b0), .mode_i(1'b0), .hpd_i(1'b0),
    .rd_addr_i(ra2), .rd_data_o(rd2));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  int e_sel = 0, e_hpdt = 0, e_ort = 0, e_hpdc = 0, e_orc = 0;
  int last_sel = -100000, last_mode = -100000;
  bit sel_hit_now = 0;
  logic [31:0] w;

  function automatic int sat(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdw(input int a, output logic [31:0] d);
    ra = AW'(a);
    @(negedge clk);
    d = rd;
  endtask

  task automatic d_sel(input logic v);
    if (v != sel) begin
      sel_hit_now = (cyc - last_mode <= WIN);
      if (sel_hit_now) e_sel++;
      last_sel = cyc;
    end
    sel = v;
  endtask

  task automatic d_mode(input logic v);
    if (v && !mode) begin
      if (last_sel == cyc) begin
        if (!sel_hit_now) e_sel++;
      end else if (cyc - last_sel <= WIN) e_sel++;
      last_mode = cyc;
    end
    mode = v;
  endtask

  task automatic d_att(input logic v);
    if (v && !att) begin e_hpdc = 0; e_orc = 0; end
    if (!v && att) begin
      if (e_hpdc != 1) e_hpdt++;
      if (e_orc != 0)  e_ort++;
    end
    att = v;
  endtask

  task automatic d_hpd(input logic v);
    if (v && !hpd && att) e_hpdc++;
    hpd = v;
  endtask

  task automatic d_ori(input logic v);
    if (v != ori && att) e_orc++;
    ori = v;
  endtask

  task automatic chk_counts(input string tag);
    rdw(A_SEL, w); chk({tag, " R6 sel total"}, w, 32'(sat(e_sel)));
    rdw(A_HPD, w); chk({tag, " R7 hpd total"}, w, 32'(sat(e_hpdt)));
    rdw(A_ORI, w); chk({tag, " R8 orient total"}, w, 32'(sat(e_ort)));
    rdw(A_PA, w);  chk({tag, " R9 per-attach"}, w, 32'((sat(e_orc) << 8) | sat(e_hpdc)));
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [31:0] e0, e1, e2, e3, base;
    seed = $urandom(32'd20240611);
    step(4);
    rst = 1'b0;
    step(2);

    // R1 / R11: everything zero after reset, unmapped included
    for (int a = 0; a < 16; a++) begin
      rdw(a, w); chk("R1 reset word", w, 32'h0);
    end

    // R2 / R3: entries and spacing
    d_ori(1); step(5);
    d_att(1); step(9);
    d_sel(1); step(3);
    d_hpd(1); step(6);
    rdw(0, e0); rdw(1, e1); rdw(2, e2); rdw(3, e3);
    chk("R2 entry0 snap", e0[5:0], 32'h02);
    chk("R2 entry1 snap", e1[5:0], 32'h03);
    chk("R2 entry2 snap", e2[5:0], 32'h07);
    chk("R2 entry3 snap", e3[5:0], 32'h27);
    chk("R3 delta 0-1", e1[29:6] - e0[29:6], 32'd5);
    chk("R3 delta 1-2", e2[29:6] - e1[29:6], 32'd9);
    chk("R3 delta 2-3", e3[29:6] - e2[29:6], 32'd3);
    rdw(4, w); chk("R11 unwritten slot", w, 32'h0);

    // R4: overflow keeps the oldest
    for (int k = 0; k < 6; k++) begin
      en = ~en; step(2);
    end
    step(5);
    rdw(A_ST, w); chk("R4 full status", w, 32'h108);
    rdw(4, w);    chk("R4 entry4 snap", w[5:0], 32'h2F);
    rdw(7, w);    chk("R4 entry7 snap", w[5:0], 32'h27);

    // R10: clear
    clr = 1'b1; step(1); clr = 1'b0;
    e_sel = 0; e_hpdt = 0; e_ort = 0;
    step(2);
    rdw(A_ST, w); chk("R10 status cleared", w, 32'h0);
    rdw(0, w);    chk("R10 log emptied", w, 32'h0);
    rdw(A_PA, w); chk("R10 per-attach kept", w, 32'h0001);

    // R6: window edges
    step(3 * WIN);
    base = 0;
    d_mode(1); step(WIN); d_sel(~sel); step(5);
    rdw(A_SEL, w); chk("R6 sel at +WIN", w, base + 1);
    step(3 * WIN); d_mode(0); step(3 * WIN);
    d_mode(1); step(WIN + 1); d_sel(~sel); step(5);
    rdw(A_SEL, w); chk("R6 sel at +WIN+1", w, base + 1);
    step(3 * WIN); d_mode(0); step(3 * WIN);
    d_sel(~sel); step(WIN); d_mode(1); step(5);
    rdw(A_SEL, w); chk("R6 mode at +WIN", w, base + 2);
    step(3 * WIN); d_mode(0); step(3 * WIN);
    d_sel(~sel); step(WIN + 1); d_mode(1); step(5);
    rdw(A_SEL, w); chk("R6 mode at +WIN+1", w, base + 2);
    step(3 * WIN); d_mode(0); step(3 * WIN);
    d_sel(~sel); d_mode(1); step(5);
    rdw(A_SEL, w); chk("R6 coincident once", w, base + 3);
    chk("R6 model agrees", 32'(e_sel), 32'd3);

    // R7 / R8 / R9: per-attach rules
    d_hpd(0); step(3);
    d_att(0); step(5);
    chk_counts("single pulse detach");
    step(3); d_att(1); step(5);
    rdw(A_PA, w); chk("R9 cleared on attach", w, 32'h0);
    d_hpd(1); step(3); d_hpd(0); step(3); d_hpd(1); step(3); d_hpd(0);
    step(3); d_ori(~ori); step(3);
    d_att(0); step(5);
    chk_counts("double pulse + flip");
    rdw(A_HPD, w); chk("R7 two pulses flagged", w, 32'd1);
    rdw(A_ORI, w); chk("R8 flip flagged", w, 32'd1);
    d_att(1); step(6); d_att(0); step(5);
    rdw(A_HPD, w); chk("R7 zero pulses flagged", w, 32'd2);

    // random sessions checked against the model
    for (int s = 0; s < 30; s++) begin
      d_att(1); step(1 + int'($urandom % 5));
      for (int k = 0; k < 12; k++) begin
        case ($urandom % 6)
          0, 1: d_sel(~sel);
          2:    d_mode(~mode);
          3:    d_hpd(~hpd);
          4:    if ($urandom % 4 == 0) d_ori(~ori);
          default: en = ~en;
        endcase
        step(1 + int'($urandom % (2 * WIN + 4)));
      end
      d_att(0); step(5);
      chk_counts("random session");
      step(1 + int'($urandom % 5));
    end

    // R5: timestamp that fails to increase (8-bit stamp)
    clr = 1'b1; step(1); clr = 1'b0; step(2);
    att2 = 1; step(100); att2 = 0; step(5);
    ra2 = 4'd4; step(1); chk("R5 no flag on rising stamps", rd2[9], 32'h0);
    ra2 = 4'd0; step(1); e0 = rd2;
    ra2 = 4'd1; step(1); e1 = rd2;
    chk("R3 small stamp delta", 32'((e1[13:6] - e0[13:6]) & 8'hFF), 32'd100);
    step(256 - 5 - 3);
    att2 = 1; step(6);
    ra2 = 4'd4; step(1); chk("R5 flag on equal stamp", rd2[9], 32'h1);
    step(20);
    chk("R5 flag sticky", rd2[9], 32'h1);
    clr = 1'b1; step(1); clr = 1'b0; step(2);
    chk("R10 clear drops R5 flag", rd2[9], 32'h0);

    report();
    $finish;
  end
endmodule